// File: doc/BRIEF.md
# Key-Locked Watchdog Counter

This block is a watchdog counter that leaves every reset already armed. It counts up on each pulse of a timer tick, starting from a programmable load value. When it passes the all-ones value it raises a one-clock request to the system reset controller and restarts from the load value. The only way software can stop it is to write a two-word key to the key register, in the right order. The counter then stays stopped until the next reset.

Writes to the load, reload-trigger and key registers are posted. Each one is held in a small slot for a fixed number of timer ticks, which models the crossing into a slower timer clock. While a write is held, a pending bit in the posting-status register is set. A write to a register whose slot is still busy is dropped. Software polls the pending bit before each follow-up write.

A soft-reset command returns the whole block to its reset state, which re-arms the watchdog. A reset-done flag tells software when that internal reset has finished.

Top module: `wdt_keyguard`

## Requirements
- R1: After a hard reset the watchdog is enabled and the count starts at DEFAULT_LOAD. The count rises by one on every clock where `tick` is high, and the count register is readable at byte offset 0x28.
- R2: When the count is all ones, the next tick reloads the count from the load value. On the following clock `reset_req` is high for exactly one clock.
- R3: Writing 0x0000AAAA to the key register at offset 0x48, and then 0x00005555 as the next accepted key write, stops the count. Once stopped, the count stays frozen with no `reset_req` until a reset.
- R4: The posting-status register at offset 0x34 has three pending bits: bit 2 for the load register, bit 3 for the trigger register and bit 4 for the key register. A pending bit is set from the clock after its write until the SYNC_TICKS-th tick after that. The write takes effect on that same tick.
- R5: A write to the load, trigger or key register while that register's pending bit is set is discarded.
- R6: Any accepted key write other than 0x00005555 that directly follows 0x0000AAAA cancels the partial sequence. So does 0x00005555 with no 0x0000AAAA before it. The watchdog keeps counting in each case.
- R7: Writing a 1 to bit 1 of the control register at offset 0x10 holds the block in reset for SRST_CYCLES clocks. During that time bit 0 of the status register at offset 0x14 reads 0, and afterwards it reads 1. Load, count, pending bits and key state return to their reset values, and the watchdog counts again.
- R8: Once a write to the load register (offset 0x2C) lands, the load register reads back the written value. Once a write to the trigger register (offset 0x30) lands, the count is set to the load value. On a tick where both land, the trigger uses the new load value.
- R9: `bus_rdata` is registered. It shows the selected register one clock after `bus_rd`, and offsets with no readable register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst | input | 1 | Synchronous active-high hard reset |
| tick | input | 1 | Timer-domain tick enable, one clock wide |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| reset_req | output | 1 | One-clock system reset request on overflow |

## Verification
The bench checks that the second key write is dropped when it arrives while the first key write is still pending. A design that accepted it would let software disable the watchdog without waiting for the crossing. The bench also sends 0x5555 with no 0xAAAA before it, and 0xAAAA followed by a stray value, to catch a sequence detector that does not forget its partial state and would stop the counter. The bench checks the overflow wrap and the reset-request pulse width, and a trigger that must reload from the newly written load value. After a soft reset it looks for a cleared reset-done flag, a restored load value and a running count. A design that skipped the re-arm would leave the counter frozen at that point.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int AW = 8;
  localparam int DW = 32;

  localparam logic [AW-1:0] OFS_CTRL   = 8'h10;
  localparam logic [AW-1:0] OFS_STATUS = 8'h14;
  localparam logic [AW-1:0] OFS_COUNT  = 8'h28;
  localparam logic [AW-1:0] OFS_LOAD   = 8'h2C;
  localparam logic [AW-1:0] OFS_TRIG   = 8'h30;
  localparam logic [AW-1:0] OFS_PEND   = 8'h34;
  localparam logic [AW-1:0] OFS_KEY    = 8'h48;

  localparam int CTRL_SRST_BIT  = 1;
  localparam int STAT_DONE_BIT  = 0;

  localparam logic [DW-1:0] KEY_FIRST  = 32'h0000_AAAA;
  localparam logic [DW-1:0] KEY_SECOND = 32'h0000_5555;

  // posted slots: index, register offset and pending bit position
  localparam int NSLOT     = 3;
  localparam int SLOT_LOAD = 0;
  localparam int SLOT_TRIG = 1;
  localparam int SLOT_KEY  = 2;

  function automatic logic [AW-1:0] slot_ofs(input int idx);
    case (idx)
      SLOT_LOAD: slot_ofs = OFS_LOAD;
      SLOT_TRIG: slot_ofs = OFS_TRIG;
      default:   slot_ofs = OFS_KEY;
    endcase
  endfunction

  function automatic int slot_pend_bit(input int idx);
    case (idx)
      SLOT_LOAD: slot_pend_bit = 2;
      SLOT_TRIG: slot_pend_bit = 3;
      default:   slot_pend_bit = 4;
    endcase
  endfunction

  typedef enum logic {KS_IDLE, KS_HALF} key_state_t;
endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
  parameter int DW         = 32,
  parameter int SYNC_TICKS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          pend,
  output logic          apply,
  output logic [DW-1:0] data
);
  localparam int CW = $clog2(SYNC_TICKS + 1);

  logic [CW-1:0] left;

  assign apply = pend && tick && (left == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      left <= '0;
    end else if (!pend) begin
      if (wr) begin
        pend <= 1'b1;
        left <= CW'(SYNC_TICKS);
      end
    end else if (tick) begin
      if (left == CW'(1)) pend <= 1'b0;
      else                left <= left - CW'(1);
    end
  end

  // data holder carries no reset; only read while pend is set
  always_ff @(posedge clk) begin
    if (wr && !pend) data <= wdata;
  end
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
  import wdt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_apply,
  input  logic [DW-1:0] key_data,
  output logic          en
);
  key_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= KS_IDLE;
      en    <= 1'b1;
    end else if (key_apply) begin
      if (key_data == DW'(KEY_FIRST)) begin
        state <= KS_HALF;
      end else if (key_data == DW'(KEY_SECOND) && state == KS_HALF) begin
        state <= KS_IDLE;
        en    <= 1'b0;
      end else begin
        state <= KS_IDLE;
      end
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int          DW           = 32,
  parameter logic [DW-1:0] DEFAULT_LOAD = 32'hFFFF_FFC0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic          load_apply,
  input  logic [DW-1:0] load_data,
  input  logic          trig_apply,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] load_q,
  output logic          req
);
  logic [DW-1:0] load_nxt;

  assign load_nxt = load_apply ? load_data : load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= DEFAULT_LOAD;
      load_q <= DEFAULT_LOAD;
      req    <= 1'b0;
    end else begin
      load_q <= load_nxt;
      req    <= 1'b0;
      if (trig_apply) begin
        cnt <= load_nxt;
      end else if (en && tick) begin
        if (&cnt) begin
          cnt <= load_nxt;
          req <= 1'b1;
        end else begin
          cnt <= cnt + DW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wdt_keyguard.sv
module wdt_keyguard
  import wdt_pkg::*;
#(
  parameter int            SYNC_TICKS   = 3,
  parameter int            SRST_CYCLES  = 4,
  parameter logic [DW-1:0] DEFAULT_LOAD = 32'hFFFF_FFC0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          reset_req
);
  localparam int SW = $clog2(SRST_CYCLES + 1);

  logic [SW-1:0]    srst_left;
  logic             busy;
  logic             irst;
  logic [NSLOT-1:0] slot_wr;
  logic [NSLOT-1:0] slot_pend;
  logic [NSLOT-1:0] slot_apply;
  logic [DW-1:0]    slot_data [NSLOT];
  logic             wd_en;
  logic [DW-1:0]    cnt;
  logic [DW-1:0]    load_q;
  logic [DW-1:0]    pend_word;
  logic [DW-1:0]    rd_mux;

  assign busy = (srst_left != '0);
  assign irst = rst | busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      srst_left <= '0;
    end else if (busy) begin
      srst_left <= srst_left - SW'(1);
    end else if (bus_wr && bus_addr == OFS_CTRL && bus_wdata[CTRL_SRST_BIT]) begin
      srst_left <= SW'(SRST_CYCLES);
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_wr[g] = bus_wr && (bus_addr == slot_ofs(g));
    wdt_post_slot #(.DW(DW), .SYNC_TICKS(SYNC_TICKS)) u_slot (
      .clk   (clk),
      .rst   (irst),
      .tick  (tick),
      .wr    (slot_wr[g]),
      .wdata (bus_wdata),
      .pend  (slot_pend[g]),
      .apply (slot_apply[g]),
      .data  (slot_data[g])
    );
  end

  wdt_key_fsm #(.DW(DW)) u_key (
    .clk       (clk),
    .rst       (irst),
    .key_apply (slot_apply[SLOT_KEY]),
    .key_data  (slot_data[SLOT_KEY]),
    .en        (wd_en)
  );

  wdt_counter #(.DW(DW), .DEFAULT_LOAD(DEFAULT_LOAD)) u_cnt (
    .clk        (clk),
    .rst        (irst),
    .tick       (tick),
    .en         (wd_en),
    .load_apply (slot_apply[SLOT_LOAD]),
    .load_data  (slot_data[SLOT_LOAD]),
    .trig_apply (slot_apply[SLOT_TRIG]),
    .cnt        (cnt),
    .load_q     (load_q),
    .req        (reset_req)
  );

  always_comb begin
    pend_word = '0;
    for (int i = 0; i < NSLOT; i++) pend_word[slot_pend_bit(i)] = slot_pend[i];
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_STATUS: rd_mux[STAT_DONE_BIT] = !busy;
      OFS_COUNT:  rd_mux = cnt;
      OFS_LOAD:   rd_mux = load_q;
      OFS_PEND:   rd_mux = pend_word;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/wdt_keyguard_chk.sv
module wdt_keyguard_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          tick,
  input logic          reset_req,
  input logic          en,
  input logic [DW-1:0] cnt,
  input logic          trig_apply,
  input logic          key_pend,
  input logic          key_apply,
  input logic [DW-1:0] key_data
);
  // R1: one step per tick while enabled and not reloading
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst || busy)
    (en && tick && !trig_apply && !(&cnt)) |=> (cnt == $past(cnt) + {{(DW-1){1'b0}}, 1'b1}));

  // R2: a reset request only follows a tick
  a_r2_req_after_tick: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(tick));

  // R3: once stopped, stays stopped outside soft reset
  a_r3_off_sticks: assert property (@(posedge clk) disable iff (rst)
    (!en && !busy) |=> !en);

  // R4: a key write lands only on a tick while pending
  a_r4_apply_on_tick: assert property (@(posedge clk) disable iff (rst)
    key_apply |-> (tick && key_pend));

  // R5: held key data cannot be replaced while pending
  a_r5_hold_pending: assert property (@(posedge clk) disable iff (rst || busy)
    key_pend |=> $stable(key_data));

  // R7: soft reset re-arms the watchdog
  a_r7_rearm: assert property (@(posedge clk) disable iff (rst)
    busy |=> en);
endmodule

bind wdt_keyguard wdt_keyguard_chk #(.DW(wdt_pkg::DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .tick       (tick),
  .reset_req  (reset_req),
  .en         (wd_en),
  .cnt        (cnt),
  .trig_apply (slot_apply[wdt_pkg::SLOT_TRIG]),
  .key_pend   (slot_pend[wdt_pkg::SLOT_KEY]),
  .key_apply  (slot_apply[wdt_pkg::SLOT_KEY]),
  .key_data   (slot_data[wdt_pkg::SLOT_KEY])
);

// File: tb/sim_wdt_keyguard.sv
`timescale 1ns/1ps
module sim_wdt_keyguard;
  import wdt_pkg::*;

  localparam int          SYNC = 3;
  localparam int          SRST = 4;
  localparam logic [31:0] DL   = 32'hFFFF_FFC0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        reset_req;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int tdiv = 2;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wdt_keyguard #(.SYNC_TICKS(SYNC), .SRST_CYCLES(SRST), .DEFAULT_LOAD(DL)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .reset_req(reset_req)
  );

  // ---------------- behavioural reference model ----------------
  int          m_busy;
  bit          m_en, m_half, m_req;
  logic [31:0] m_cnt, m_load, m_rdata;
  bit          m_pend [3];
  int          m_left [3];
  logic [31:0] m_pdata [3];

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] v;
    v = '0;
    if (a == OFS_STATUS) v[0] = (m_busy == 0);
    else if (a == OFS_COUNT) v = m_cnt;
    else if (a == OFS_LOAD) v = m_load;
    else if (a == OFS_PEND) begin
      v[2] = m_pend[0]; v[3] = m_pend[1]; v[4] = m_pend[2];
    end
    return v;
  endfunction

  function automatic logic [7:0] m_ofs(input int i);
    return (i == 0) ? OFS_LOAD : (i == 1) ? OFS_TRIG : OFS_KEY;
  endfunction

  always @(posedge clk) begin
    bit ap [3];
    logic [31:0] nl;
    if (rst) begin
      m_rdata = '0;
    end else if (bus_rd) begin
      m_rdata = m_read(bus_addr);
    end
    if (rst || m_busy > 0) begin
      if (!rst) m_busy = m_busy - 1; else m_busy = 0;
      m_en = 1; m_half = 0; m_req = 0; m_cnt = DL; m_load = DL;
      for (int i = 0; i < 3; i++) begin m_pend[i] = 0; m_left[i] = 0; end
    end else begin
      for (int i = 0; i < 3; i++) ap[i] = m_pend[i] && tick && (m_left[i] == 1);
      nl = ap[0] ? m_pdata[0] : m_load;
      m_req = 0;
      if (ap[1]) m_cnt = nl;
      else if (m_en && tick) begin
        if (m_cnt == 32'hFFFF_FFFF) begin m_cnt = nl; m_req = 1; end
        else m_cnt = m_cnt + 32'd1;
      end
      m_load = nl;
      if (ap[2]) begin
        if (m_pdata[2] == 32'h0000_AAAA) m_half = 1;
        else if (m_pdata[2] == 32'h0000_5555 && m_half) begin m_en = 0; m_half = 0; end
        else m_half = 0;
      end
      for (int i = 0; i < 3; i++) begin
        if (!m_pend[i]) begin
          if (bus_wr && bus_addr == m_ofs(i)) begin
            m_pend[i] = 1; m_left[i] = SYNC; m_pdata[i] = bus_wdata;
          end
        end else if (tick) begin
          if (m_left[i] == 1) m_pend[i] = 0;
          else m_left[i] = m_left[i] - 1;
        end
      end
      if (bus_wr && bus_addr == OFS_CTRL && bus_wdata[1]) m_busy = SRST;
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (reset_req !== m_req) begin
        errors++;
        $display("FAIL R2 reset_req actual=%0b expected=%0b", reset_req, m_req);
      end
      checks++;
      if (bus_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R9 rdata actual=%h expected=%h", bus_rdata, m_rdata);
      end
      if (reset_req) pulses++;
    end
  end

  // tick driver
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ph++;
      tick = (ph % tdiv) == 0;
    end
  end

  // ---------------- tasks ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_clear(input int b);
    logic [31:0] v;
    for (int k = 0; k < 60; k++) begin
      rd(OFS_PEND, v);
      if (!v[b]) return;
    end
  endtask

  task automatic finish_run;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] a, b;
    int p0;
    repeat (4) @(negedge clk);
    rst = 0;

    // R7 / R9: reset state
    rd(OFS_STATUS, a); check("R7 done after hard reset", a, 32'h1);
    rd(OFS_PEND, a);   check("R4 no pending after reset", a, 32'h0);
    rd(OFS_LOAD, a);   check("R1 load default", a, DL);
    rd(8'h00, a);      check("R9 unmapped offset", a, 32'h0);

    // R1: counting from reset
    rd(OFS_COUNT, a); idle(8); rd(OFS_COUNT, b);
    check("R1 count moves after reset", 32'(b != a), 32'h1);

    // R2: overflow pulse
    idle(200);
    check("R2 overflow pulse seen", 32'(pulses >= 1), 32'h1);

    // R8 / R4 / R5: load and trigger
    wr(OFS_LOAD, 32'hFFFF_FF00);
    rd(OFS_PEND, a); check("R4 load pending bit2", a & 32'h1C, 32'h04);
    wait_clear(2);
    rd(OFS_LOAD, a); check("R8 load readback", a, 32'hFFFF_FF00);
    wr(OFS_TRIG, 32'h1);
    wr(OFS_TRIG, 32'h1);
    rd(OFS_PEND, a); check("R4 trig pending bit3", a & 32'h1C, 32'h08);
    wait_clear(3);
    rd(OFS_COUNT, a);
    check("R8 trigger reloads", 32'(a < 32'hFFFF_FF10 && a >= 32'hFFFF_FF00), 32'h1);
    // both land on same tick: trigger takes the new load
    tdiv = 4; idle(4);
    wr(OFS_LOAD, 32'hFFFF_FF80); wr(OFS_TRIG, 32'h0);
    wait_clear(2); wait_clear(3);
    rd(OFS_COUNT, a);
    check("R8 trigger with fresh load", 32'(a >= 32'hFFFF_FF80 && a < 32'hFFFF_FF90), 32'h1);
    tdiv = 2;

    // R6: wrong orders
    wr(OFS_KEY, 32'h5555); wait_clear(4);
    wr(OFS_KEY, 32'hAAAA); wait_clear(4);
    wr(OFS_KEY, 32'h1234); wait_clear(4);
    wr(OFS_KEY, 32'h5555); wait_clear(4);
    rd(OFS_COUNT, a); idle(10); rd(OFS_COUNT, b);
    check("R6 wrong order keeps counting", 32'(b != a), 32'h1);

    // R5: second key dropped while first pending
    wr(OFS_KEY, 32'hAAAA);
    rd(OFS_PEND, a); check("R4 key pending bit4", a & 32'h1C, 32'h10);
    wr(OFS_KEY, 32'h5555);
    wait_clear(4);
    rd(OFS_COUNT, a); idle(10); rd(OFS_COUNT, b);
    check("R5 key during pending ignored", 32'(b != a), 32'h1);
    wr(OFS_KEY, 32'h0); wait_clear(4);

    // R3: correct sequence stops it
    wr(OFS_KEY, 32'hAAAA); wait_clear(4);
    wr(OFS_KEY, 32'h5555); wait_clear(4);
    idle(2);
    p0 = pulses;
    rd(OFS_COUNT, a); idle(600); rd(OFS_COUNT, b);
    check("R3 count frozen", b, a);
    check("R3 no reset request", 32'(pulses), 32'(p0));

    // R7: soft reset re-arms
    wr(OFS_LOAD, 32'h1234_5678);
    wr(OFS_CTRL, 32'h2);
    rd(OFS_STATUS, a); check("R7 done low in soft reset", a, 32'h0);
    idle(SRST + 2);
    rd(OFS_STATUS, a); check("R7 done high after", a, 32'h1);
    rd(OFS_LOAD, a);   check("R7 load restored", a, DL);
    rd(OFS_PEND, a);   check("R7 pending cleared", a, 32'h0);
    rd(OFS_COUNT, a); idle(10); rd(OFS_COUNT, b);
    check("R7 counting again", 32'(b != a), 32'h1);
    p0 = pulses; idle(200);
    check("R2 R7 overflow after re-arm", 32'(pulses > p0), 32'h1);

    finish_run();
  end
endmodule